// File: doc/BRIEF.md
# Partitioned Pixel Pack Unit

This block converts fixed-point data packed into a 64-bit operand into narrower pixel formats. Three saturating pack modes scale each signed lane by a shift amount, drop a mode-specific number of fraction bits and clamp the result to the range of the narrow format. Two non-arithmetic modes widen four bytes into 16-bit lanes, or interleave the bytes of two 32-bit words.

A request carries an operation code, two 64-bit sources and the scale field of a global status word. The result and its valid flag come from one register stage, one clock after the request. Instruction decode and register-file access happen outside the block. An operation code outside the five supported ones returns zero and raises an error flag.

Top module: `pix_pack_unit`

## Requirements
- R1: When `req_valid` is high at a rising edge, `res_valid` is high after that edge, and `res_data` and `res_err` hold that request's result. When `req_valid` is low, `res_valid` and `res_err` are low after the edge. A synchronous active-low reset clears `res_valid`, `res_err` and `res_data`.
- R2: `stat_scale` carries bits 7:3 of the status word. The 32-bit pack modes use all five bits as the shift. The 16-to-8 pack (op 0) uses only bits 3:0, so bit 4 has no effect on its result.
- R3: Op 0 (16-to-8 pack) takes each signed 16-bit lane i of `src_b`, shifts it left by the scale and then arithmetically right by 7.
- R4: Op 0 clamps each lane value to 0..255 and places lane i in byte i of `res_data[31:0]`. `res_data[63:32]` is zero.
- R5: Op 1 (32-to-8 pack) starts from `src_a` shifted left by 8 bits, with byte 0 and byte 4 cleared.
- R6: Op 1 takes each signed 32-bit half w of `src_b`, shifts it left by the scale and arithmetically right by 23, and clamps it to 0..255. The clamped value fills byte 0 of half w.
- R7: Op 2 (32-to-16 fixed pack) computes (signed half w of `src_b` << scale) >>> 16 and saturates it to -32768..32767. Half 0 goes to `res_data[15:0]`, half 1 to `res_data[31:16]`, and `res_data[63:32]` is zero.
- R8: Op 3 (expand) places byte i of `src_b[31:0]`, shifted left by 4, into 16-bit lane i. All other bits are zero.
- R9: Op 4 (merge) produces bytes 2k = `src_b` byte k and bytes 2k+1 = `src_a` byte k, for k = 0..3.
- R10: Ops 5, 6 and 7 give `res_data` = 0 and `res_err` = 1, together with `res_valid`. Supported ops give `res_err` = 0.
- R11: The left shift loses no bits before saturation. Example: a 32-bit lane 0x40000000 with scale 31 clamps to 255 in op 1 and to 32767 in op 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request accepted this cycle |
| req_op | input | 3 | Operation code: 0 pack16, 1 pack32, 2 fixed pack, 3 expand, 4 merge |
| src_a | input | 64 | First source (accumulator for op 1, odd bytes for op 4) |
| src_b | input | 64 | Second source (lanes to pack, expand or merge) |
| stat_scale | input | 5 | Scale field, status word bits 7:3 |
| res_valid | output | 1 | Result valid |
| res_data | output | 64 | Result |
| res_err | output | 1 | Unsupported operation flag |

## Verification
In op 1, the shifted accumulator and the clamped lane value meet in the same byte. The bench drives `src_a` with all-ones bytes and saturating lanes, and expects only the clamped value in bytes 0 and 4. A second overlap is the register update in back-to-back cycles. Requests are issued with no idle gap, and unsupported codes are mixed between good ones. Each cycle's data and error flag must belong to its own request and must not carry over from the one before.

// File: rtl/pix_pack_pkg.sv
// Shared widths and operation codes for the pixel pack unit.
// Assumes a 64-bit operand holding four 16-bit or two 32-bit lanes.
package pix_pack_pkg;
    localparam int DATA_W  = 64;
    localparam int HALF_W  = DATA_W / 2;
    localparam int SCALE_W = 5;
    localparam int OP_W    = 3;
    localparam int N16     = DATA_W / 16;
    localparam int N32     = DATA_W / 32;

    typedef enum logic [OP_W-1:0] {
        OP_PACK8_16 = 3'd0,
        OP_PACK8_32 = 3'd1,
        OP_PACK16   = 3'd2,
        OP_EXPAND   = 3'd3,
        OP_MERGE    = 3'd4
    } pix_op_e;
endpackage

// File: rtl/pix_sat_lane.sv
// One lane of a saturating pack: sign-extends the lane into EXT_W bits,
// shifts left by the scale, shifts right arithmetically by FRAC, then
// clamps to the signed or unsigned OUT_W range.
// Assumes EXT_W >= IN_W + 2**SCALE_W - 1, so the left shift never drops bits.
module pix_sat_lane #(
    parameter int IN_W       = 16,
    parameter int SCALE_W    = 4,
    parameter int EXT_W      = 32,
    parameter int FRAC       = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [IN_W-1:0]    lane_in,
    input  logic [SCALE_W-1:0] scale,
    output logic [OUT_W-1:0]   lane_out
);
    localparam longint HI_L = SIGNED_OUT ? (longint'(1) <<< (OUT_W-1)) - 1
                                         : (longint'(1) <<< OUT_W) - 1;
    localparam longint LO_L = SIGNED_OUT ? -(longint'(1) <<< (OUT_W-1)) : 0;
    localparam logic signed [EXT_W-1:0] HI = EXT_W'(HI_L);
    localparam logic signed [EXT_W-1:0] LO = EXT_W'(LO_L);

    logic signed [EXT_W-1:0] ext_v, shl_v, fix_v;

    // Widen, scale and drop the fraction bits.
    always_comb begin
        ext_v = {{(EXT_W-IN_W){lane_in[IN_W-1]}}, lane_in};
        shl_v = ext_v <<< scale;
        fix_v = shl_v >>> FRAC;
    end

    // Clamp into the narrow format.
    always_comb begin
        if (fix_v > HI)      lane_out = HI[OUT_W-1:0];
        else if (fix_v < LO) lane_out = LO[OUT_W-1:0];
        else                 lane_out = fix_v[OUT_W-1:0];
    end
endmodule

// File: rtl/pix_reformat.sv
// Non-arithmetic formats: expands bytes into 16-bit lanes (4 fraction
// bits) and interleaves the bytes of two 32-bit words.
// Assumes only the low 32 bits of each source matter.
module pix_reformat #(
    parameter int NBYTES = 4
) (
    input  logic [8*NBYTES-1:0]  word_a,
    input  logic [8*NBYTES-1:0]  word_b,
    output logic [16*NBYTES-1:0] expanded,
    output logic [16*NBYTES-1:0] merged
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Byte i becomes lane i with four fraction bits.
        assign expanded[16*i +: 16] = {4'b0, word_b[8*i +: 8], 4'b0};
        // Second word in the even byte, first word in the odd byte.
        assign merged[16*i +: 8]     = word_b[8*i +: 8];
        assign merged[16*i + 8 +: 8] = word_a[8*i +: 8];
    end
endmodule

// File: rtl/pix_pack_unit.sv
// Partitioned pixel pack unit: five format conversions on 64-bit operands,
// with one register stage. Assumes the caller extracts the scale field
// (status bits 7:3) and decodes the operation code.
module pix_pack_unit
    import pix_pack_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [OP_W-1:0]    req_op,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [SCALE_W-1:0] stat_scale,
    output logic               res_valid,
    output logic [DATA_W-1:0]  res_data,
    output logic               res_err
);
    localparam int EXT32_W = 2 * HALF_W;

    logic [N16*8-1:0]   pk8_16;
    logic [N32*8-1:0]   pk8_32;
    logic [N32*16-1:0]  pk16;
    logic [DATA_W-1:0]  acc_base, pk8_32_full;
    logic [DATA_W-1:0]  exp_w, mrg_w;
    logic [DATA_W-1:0]  nxt_data;
    logic               nxt_err;
    logic               unused_top_byte;

    assign unused_top_byte = ^src_a[DATA_W-1 -: 8];

    // Four 16-bit lanes to unsigned bytes, four-bit scale.
    for (genvar i = 0; i < N16; i++) begin : g_p16
        pix_sat_lane #(.IN_W(16), .SCALE_W(SCALE_W-1), .EXT_W(32),
                       .FRAC(7), .OUT_W(8), .SIGNED_OUT(1'b0)) u_lane (
            .lane_in (src_b[16*i +: 16]),
            .scale   (stat_scale[SCALE_W-2:0]),
            .lane_out(pk8_16[8*i +: 8])
        );
    end

    // Two 32-bit lanes to unsigned bytes and to signed halfwords.
    for (genvar w = 0; w < N32; w++) begin : g_p32
        pix_sat_lane #(.IN_W(HALF_W), .SCALE_W(SCALE_W), .EXT_W(EXT32_W),
                       .FRAC(23), .OUT_W(8), .SIGNED_OUT(1'b0)) u_byte (
            .lane_in (src_b[HALF_W*w +: HALF_W]),
            .scale   (stat_scale),
            .lane_out(pk8_32[8*w +: 8])
        );
        pix_sat_lane #(.IN_W(HALF_W), .SCALE_W(SCALE_W), .EXT_W(EXT32_W),
                       .FRAC(16), .OUT_W(16), .SIGNED_OUT(1'b1)) u_half (
            .lane_in (src_b[HALF_W*w +: HALF_W]),
            .scale   (stat_scale),
            .lane_out(pk16[16*w +: 16])
        );
        // Shifted accumulator half with its low byte replaced.
        assign pk8_32_full[HALF_W*w +: HALF_W] =
            {acc_base[HALF_W*w + 8 +: HALF_W-8], pk8_32[8*w +: 8]};
    end

    assign acc_base = {src_a[DATA_W-9:0], 8'h00};

    pix_reformat #(.NBYTES(HALF_W/8)) u_fmt (
        .word_a  (src_a[HALF_W-1:0]),
        .word_b  (src_b[HALF_W-1:0]),
        .expanded(exp_w),
        .merged  (mrg_w)
    );

    // Select the result for the requested operation.
    always_comb begin
        nxt_err = 1'b0;
        case (pix_op_e'(req_op))
            OP_PACK8_16: nxt_data = {{(DATA_W-N16*8){1'b0}}, pk8_16};
            OP_PACK8_32: nxt_data = pk8_32_full;
            OP_PACK16:   nxt_data = {{(DATA_W-N32*16){1'b0}}, pk16};
            OP_EXPAND:   nxt_data = exp_w;
            OP_MERGE:    nxt_data = mrg_w;
            default: begin
                nxt_data = '0;
                nxt_err  = 1'b1;
            end
        endcase
    end

    // Output register stage; data holds while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= req_valid;
            res_err   <= req_valid & nxt_err;
            if (req_valid) res_data <= nxt_data;
        end
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !res_err));
    assert_pack16_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0) |=> res_data[63:32] == 32'h0);
    assert_pack32_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd1) |=> res_data[15:8] == $past(src_a[7:0]));
    assert_fixpack_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2) |=> res_data[63:32] == 32'h0);
    assert_expand_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3) |=> (res_data & 64'hF00F_F00F_F00F_F00F) == 64'h0);
    assert_merge_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |=>
            res_data[15:0] == {$past(src_a[7:0]), $past(src_b[7:0])});
    assert_bad_op_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> (res_valid && res_data == 64'h0));
endmodule

// File: tb/pix_pack_unit_test.sv
`timescale 1ns/1ps
module pix_pack_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [4:0]  stat_scale = '0;
    logic        res_valid, res_err;
    logic [63:0] res_data;
    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    pix_pack_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .src_a(src_a), .src_b(src_b), .stat_scale(stat_scale),
        .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
    );

    function automatic longint clampv(longint v, longint lo, longint hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    // R3/R4 model.
    function automatic logic [63:0] m_p16(logic [63:0] b, logic [4:0] sc);
        logic [63:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            longint v = longint'($signed(b[16*i +: 16]));
            v = clampv((v <<< sc[3:0]) >>> 7, 0, 255);
            r[8*i +: 8] = v[7:0];
        end
        return r;
    endfunction

    // R5/R6 model.
    function automatic logic [63:0] m_p32(logic [63:0] a, logic [63:0] b, logic [4:0] sc);
        logic [63:0] r = (a << 8) & ~64'h0000_00FF_0000_00FF;
        for (int w = 0; w < 2; w++) begin
            longint v = longint'($signed(b[32*w +: 32]));
            v = clampv((v <<< sc) >>> 23, 0, 255);
            r[32*w +: 8] = v[7:0];
        end
        return r;
    endfunction

    // R7 model.
    function automatic logic [63:0] m_fix(logic [63:0] b, logic [4:0] sc);
        logic [63:0] r = '0;
        for (int w = 0; w < 2; w++) begin
            longint v = longint'($signed(b[32*w +: 32]));
            v = clampv((v <<< sc) >>> 16, -32768, 32767);
            r[16*w +: 16] = v[15:0];
        end
        return r;
    endfunction

    // R8 model.
    function automatic logic [63:0] m_exp(logic [63:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(b[8*i +: 8]) * 16;
        return r;
    endfunction

    // R9 model.
    function automatic logic [63:0] m_mrg(logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            r[16*k +: 8]     = b[8*k +: 8];
            r[16*k + 8 +: 8] = a[8*k +: 8];
        end
        return r;
    endfunction

    function automatic logic [63:0] vec(int k);
        case (k % 7)
            0: return 64'h7FFF_8000_0080_FFFF;
            1: return 64'h7FFF_FFFF_8000_0000;
            2: return 64'h0001_0000_FFFE_FFFF;
            3: return 64'h4000_0000_0080_0000;
            4: return 64'hFFFF_FF00_0000_0100;
            default: return {32'(k) * 32'h9E37_79B9, 32'(k * k + 7) * 32'h85EB_CA6B};
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge, check after the next rising edge.
    task automatic issue(logic [2:0] op, logic [63:0] a, logic [63:0] b,
                         logic [4:0] sc, string tag, logic [63:0] exp, logic eerr);
        req_valid = 1'b1; req_op = op; src_a = a; src_b = b; stat_scale = sc;
        @(negedge clk);
        check({tag, " valid (R1)"}, {63'b0, res_valid}, 64'd1);
        check({tag, " err (R10)"},  {63'b0, res_err},   {63'b0, eerr});
        check(tag, res_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'b0, res_valid}, 64'd0);
        check("R1 reset err",   {63'b0, res_err},   64'd0);
        check("R1 reset data",  res_data,           64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int sc = 0; sc < 32; sc++)
            for (int k = 0; k < 14; k++) begin
                issue(3'd0, vec(k + 3), vec(k), 5'(sc), "R2 R3 R4 pack16",
                      m_p16(vec(k), 5'(sc)), 1'b0);
                issue(3'd1, ~vec(k + 1), vec(k), 5'(sc), "R2 R5 R6 pack32",
                      m_p32(~vec(k + 1), vec(k), 5'(sc)), 1'b0);
                issue(3'd2, vec(k + 2), vec(k), 5'(sc), "R2 R7 fixpack",
                      m_fix(vec(k), 5'(sc)), 1'b0);
                issue(3'(5 + (k % 3)), vec(k), vec(k + 1), 5'(sc), "R10 bad op",
                      64'h0, 1'b0 | 1'b1);
            end

        // R2: scale bit 4 ignored by op 0.
        issue(3'd0, 64'h0, 64'h0001_0002_0040_0100, 5'h13, "R2 bit4 ignored",
              m_p16(64'h0001_0002_0040_0100, 5'h03), 1'b0);
        // R11: wide intermediate keeps large shifts saturating correctly.
        issue(3'd1, 64'h0, 64'h4000_0000_4000_0000, 5'd31, "R11 pack32 wide",
              64'h0000_00FF_0000_00FF, 1'b0);
        issue(3'd2, 64'h0, 64'h4000_0000_C000_0000, 5'd31, "R11 fixpack wide",
              64'h0000_0000_7FFF_8000, 1'b0);
        // R5/R6: accumulator byte cleared before the clamp fills it.
        issue(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 5'd0,
              "R5 R6 low byte clear", 64'hFFFF_FF00_FFFF_FF00, 1'b0);

        for (int k = 0; k < 100; k++) begin
            issue(3'd3, vec(k + 5), vec(k), 5'(k), "R8 expand", m_exp(vec(k)), 1'b0);
            issue(3'd4, vec(k + 9), vec(k), 5'(k), "R9 merge",
                  m_mrg(vec(k + 9), vec(k)), 1'b0);
        end

        // R1: idle cycle drops valid and error, data holds.
        issue(3'd6, 64'h1, 64'h2, 5'd0, "R10 before idle", 64'h0, 1'b1);
        req_valid = 1'b0; req_op = 3'd0; src_b = 64'h1234;
        @(negedge clk);
        check("R1 idle valid", {63'b0, res_valid}, 64'd0);
        check("R1 idle err",   {63'b0, res_err},   64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule